// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block is a CPU-attached, full-duplex synchronous serial port with three wires: a serial clock, a data output and a data input. No select line is involved. The port is either the clock master or a clock slave. As master it divides the system clock down to a serial clock at one of two fixed rates. As slave it follows an external clock. That external clock is brought into the system clock domain through a flop synchroniser, and its edges are detected there.

A single data register serves the CPU and the wire. A CPU write loads it and, in master mode, starts a transfer. Bits leave on falling serial-clock edges and arrive on rising edges, so after eight rising edges the same register holds the received byte. A control register selects the master or slave role, the rate, the bit order, the port enable and the interrupt enable. A status register reports the end of a transfer and any write that collided with a transfer in progress. Both flags clear by a status read followed by an access to the data register.

Top module: `spi3w_port`

## Requirements
- R1: The address map is control at 0, status at 1 and data at 2. Address 3 reads as zero. Control bits are: bit0 master, bit1 slow rate, bit2 LSB first, bit3 port enable, bit4 interrupt enable. Control reads back as written. After reset every register reads 0, and `sclkOut`, `serOut` and `irq` are low.
- R2: In master mode with the port enabled, a data write while idle starts a transfer. That transfer makes exactly eight high pulses on `sclkOut`, and the clock idles low.
- R3: With slow rate clear, the master serial clock period is 2 system cycles. With it set, the period is 16 system cycles.
- R4: The transfer is full duplex. Each transmitted bit is valid on `serOut` at the rising serial edge. `serIn` is sampled on the rising edge. Once the transfer completes, the data register reads the received byte.
- R5: LSB first clear sends and receives bit 7 first. LSB first set sends and receives bit 0 first.
- R6: In slave mode the shift clock comes from `sclkIn` through a synchroniser. Each `sclkIn` phase is held at least four system cycles. No data write is needed to shift.
- R7: Status bit 7 (transfer done) sets when the eighth bit has been sampled.
- R8: A data write while a transfer is in progress sets status bit 6 (collision). The shifting byte is left intact and the transfer continues.
- R9: Both flags clear on a data-register read or write that follows a status read which saw a flag set. A data access without that prior status read leaves the flags set.
- R10: `irq` is high exactly while interrupt enable and transfer done are both set.
- R11: With port enable clear, no transfer starts or continues. `sclkOut` and `serOut` stay low, and clearing the enable mid-transfer aborts it without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (drives flag-clear sequencing) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational on busAddr |
| irq | output | 1 | Interrupt request |
| sclkOut | output | 1 | Serial clock driven in master mode |
| sclkIn | input | 1 | External serial clock used in slave mode |
| serOut | output | 1 | Serial data out |
| serIn | input | 1 | Serial data in |

## Verification
The properties assume that the control register is not rewritten while a fast-rate master high phase is in flight. They also assume that the external clock is held low while the port runs as master. The stimulus changes control only between transfers, with one exception: the abort case, which clears only the enable. `sclkIn` stays low in every master test. In slave tests each `sclkIn` phase lasts four system cycles, and `serIn` changes only at the start of a low phase. This keeps the synchroniser's three-cycle delay inside each phase.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Control register fields, bit0 = master .. bit4 = interrupt enable
  typedef struct packed {
    logic intEn;
    logic en;
    logic lsbFirst;
    logic slow;
    logic master;
  } ctlBits_t;

  // Strobes from control to the shift datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shiftOut;
    logic lsbFirst;
    logic enable;
  } shStrobe_t;

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              sclkIn,
  output ctlBits_t          ctl,
  output logic              doneFlag,
  output logic              colFlag,
  output logic              armed,
  output logic              busyAll,
  output logic              sclkOut,
  output logic              irq,
  output shStrobe_t         strb
);
  localparam int HALF_FAST = FAST_DIV / 2;
  localparam int HALF_SLOW = SLOW_DIV / 2;
  localparam int CNT_W     = $clog2(HALF_SLOW) + 1;
  localparam int BIT_W     = $clog2(DATA_W) + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(DATA_W);

  logic             busyM, sckLvl, prevS, syncS;
  logic [CNT_W-1:0] halfCnt, halfLast;
  logic [BIT_W-1:0] bitCnt;
  logic wrCtl, wrDat, rdStat, dataAcc, flagClr;
  logic startM, tick, mRise, mFall, sRise, sFall;
  logic sample, fallAny, endM, doneEvt, colEvt;

  spi3w_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .din(sclkIn), .dout(syncS)
  );

  always_comb begin
    wrCtl    = busWr && (busAddr == ADDR_CTL);
    wrDat    = busWr && (busAddr == ADDR_DATA);
    rdStat   = busRd && (busAddr == ADDR_STAT);
    dataAcc  = (busWr || busRd) && (busAddr == ADDR_DATA);
    flagClr  = dataAcc && armed;
    busyAll  = busyM || (bitCnt != '0);
    halfLast = ctl.slow ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
    startM   = wrDat && !busyAll && ctl.en && ctl.master;
    tick     = busyM && ctl.en && ctl.master && (halfCnt == halfLast);
    mRise    = tick && !sckLvl;
    mFall    = tick && sckLvl;
    sRise    = ctl.en && !ctl.master && syncS && !prevS;
    sFall    = ctl.en && !ctl.master && !syncS && prevS;
    sample   = mRise || sRise;
    fallAny  = mFall || sFall;
    endM     = mFall && (bitCnt == ALL_BITS);
    doneEvt  = sample && (bitCnt == LAST_BIT);
    colEvt   = wrDat && busyAll;

    strb.load     = wrDat && !busyAll;
    strb.sample   = sample;
    strb.shiftOut = fallAny && (bitCnt != '0) && (bitCnt != ALL_BITS);
    strb.lsbFirst = ctl.lsbFirst;
    strb.enable   = ctl.en;
  end

  // Register file and transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl     <= '0;
      busyM   <= 1'b0;
      sckLvl  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      prevS   <= 1'b0;
    end else begin
      prevS <= syncS;
      if (wrCtl) ctl <= ctlBits_t'(busWrData[4:0]);
      if (!ctl.en) begin
        busyM   <= 1'b0;
        sckLvl  <= 1'b0;
        halfCnt <= '0;
        bitCnt  <= '0;
      end else begin
        if (startM) begin
          busyM   <= 1'b1;
          sckLvl  <= 1'b0;
          halfCnt <= '0;
        end else if (busyM && ctl.master) begin
          if (tick) begin
            halfCnt <= '0;
            sckLvl  <= ~sckLvl;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
          if (endM) busyM <= 1'b0;
        end
        if (sample)
          bitCnt <= (!ctl.master && bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        else if (endM)
          bitCnt <= '0;
      end
    end
  end

  // Status flags with read-then-access clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      colFlag  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (doneEvt)      doneFlag <= 1'b1;
      else if (flagClr) doneFlag <= 1'b0;
      if (colEvt)       colFlag <= 1'b1;
      else if (flagClr) colFlag <= 1'b0;
      if (flagClr)      armed <= 1'b0;
      else if (rdStat && (doneFlag || colFlag)) armed <= 1'b1;
    end
  end

  assign sclkOut = sckLvl;
  assign irq     = ctl.intEn && doneFlag;
endmodule

// File: rtl/spi3w_dp.sv
module spi3w_dp
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              serIn,
  output logic [DATA_W-1:0] shiftReg,
  output logic              serOut
);
  logic outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= wrData;
      outBit   <= strb.lsbFirst ? wrData[0] : wrData[DATA_W-1];
    end else begin
      if (strb.sample)
        shiftReg <= strb.lsbFirst ? {serIn, shiftReg[DATA_W-1:1]}
                                  : {shiftReg[DATA_W-2:0], serIn};
      if (strb.shiftOut)
        outBit <= strb.lsbFirst ? shiftReg[0] : shiftReg[DATA_W-1];
    end
  end

  assign serOut = outBit && strb.enable;
endmodule

// File: rtl/spi3w_port.sv
module spi3w_port
  import spi3w_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq,
  output logic              sclkOut,
  input  logic              sclkIn,
  output logic              serOut,
  input  logic              serIn
);
  ctlBits_t          ctl;
  shStrobe_t         strb;
  logic              doneFlag, colFlag, armed, busyAll;
  logic [DATA_W-1:0] shiftReg;

  spi3w_ctrl #(
    .DATA_W(DATA_W), .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .sclkIn(sclkIn),
    .ctl(ctl), .doneFlag(doneFlag), .colFlag(colFlag), .armed(armed),
    .busyAll(busyAll), .sclkOut(sclkOut), .irq(irq), .strb(strb)
  );

  spi3w_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWrData),
    .serIn(serIn), .shiftReg(shiftReg), .serOut(serOut)
  );

  always_comb begin
    case (busAddr)
      ADDR_CTL:  busRdData = {{(DATA_W-5){1'b0}}, ctl};
      ADDR_STAT: busRdData = {doneFlag, colFlag, {(DATA_W-2){1'b0}}};
      ADDR_DATA: busRdData = shiftReg;
      default:   busRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi3w_chk.sv
module spi3w_chk
  import spi3w_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAddr,
  input logic       busWr,
  input logic       sclkOut,
  input logic       irq,
  input ctlBits_t   ctl,
  input logic       busyAll,
  input logic       doneFlag,
  input logic       colFlag,
  input logic       armed
);
  assert_sclk_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.en |=> !sclkOut);

  assert_idle_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.en |=> !busyAll);

  assert_fast_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.en && ctl.master && !ctl.slow && sclkOut &&
     !(busWr && busAddr == ADDR_CTL)) |=> !sclkOut);

  assert_collision_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_DATA && busyAll) |=> colFlag);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ctl.intEn);

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(armed));
endmodule

bind spi3w_port spi3w_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .sclkOut(sclkOut), .irq(irq), .ctl(ctl), .busyAll(busyAll),
  .doneFlag(doneFlag), .colFlag(colFlag), .armed(armed)
);

// File: tb/spi3w_port_tb_top.sv
module spi3w_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = '0, busRdData;
  logic       irq, sclkOut, serOut;
  logic       sclkIn = 1'b0, serIn = 1'b0;
  int checks = 0, errors = 0;
  bit summaryDone = 1'b0;

  always #5 clk = ~clk;

  spi3w_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .sclkOut(sclkOut), .sclkIn(sclkIn),
    .serOut(serOut), .serIn(serIn)
  );

  // {master, slow, lsbFirst, intEn, tx, rx}
  localparam logic [19:0] VEC [0:5] = '{
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 8'h7E},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h96, 8'hC1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 8'hE8},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 8'h80},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00}
  };

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  function automatic logic bitOf(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic runMaster(input logic [7:0] tx, input logic [7:0] rx,
                           input logic lsb, input logic doCol,
                           output logic [7:0] capt, output int rises,
                           output int spacing);
    logic prevS = 1'b0;
    int cyc = 0, firstRise = 0, secondRise = 0;
    bit colDone = 1'b0;
    capt = '0; rises = 0; spacing = 0;
    serIn = bitOf(rx, 0, lsb);
    busWrite(2'd2, tx);
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      cyc++;
      if (busWr) busWr = 1'b0;
      if (sclkOut && !prevS) begin
        if (lsb) capt[rises] = serOut; else capt[7-rises] = serOut;
        if (rises == 0) firstRise = cyc;
        if (rises == 1) secondRise = cyc;
        rises++;
      end
      if (!sclkOut && prevS) begin
        if (rises < 8) serIn = bitOf(rx, rises, lsb);
        else begin
          prevS = sclkOut;
          break;
        end
      end
      if (doCol && rises == 2 && !colDone) begin
        busAddr = 2'd2; busWrData = 8'h5A; busWr = 1'b1; colDone = 1'b1;
      end
      prevS = sclkOut;
    end
    spacing = secondRise - firstRise;
    repeat (2) @(negedge clk);
  endtask

  task automatic runSlave(input logic [7:0] tx, input logic [7:0] rx,
                          input logic lsb, output logic [7:0] capt);
    capt = '0;
    busWrite(2'd2, tx);
    for (int k = 0; k < 8; k++) begin
      serIn = bitOf(rx, k, lsb);
      repeat (4) @(negedge clk);
      if (lsb) capt[k] = serOut; else capt[7-k] = serOut;
      sclkIn = 1'b1;
      repeat (4) @(negedge clk);
      if (k != 7) sclkIn = 1'b0;
    end
    repeat (4) @(negedge clk);
    sclkIn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!summaryDone) begin
      errors++;
      $display("FAIL watchdog expired");
      summaryDone = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, capt;
    int rises, spacing, highs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and address map
    busRead(2'd0, rd); check(rd == 8'h00, "R1 ctl reset", rd, 8'h00);
    busRead(2'd1, rd); check(rd == 8'h00, "R1 status reset", rd, 8'h00);
    busRead(2'd2, rd); check(rd == 8'h00, "R1 data reset", rd, 8'h00);
    check(!sclkOut && !serOut && !irq, "R1 pins reset",
          {sclkOut, serOut, irq}, 3'b000);
    busWrite(2'd0, 8'h1F);
    busRead(2'd0, rd); check(rd == 8'h1F, "R1 ctl readback", rd, 8'h1F);
    busRead(2'd3, rd); check(rd == 8'h00, "R1 unused addr", rd, 8'h00);
    busWrite(2'd0, 8'h00);

    // R11 port disabled: write loads but nothing shifts
    busWrite(2'd0, 8'h01);
    busWrite(2'd2, 8'h77);
    highs = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (sclkOut || serOut) highs++;
    end
    check(highs == 0, "R11 disabled pins quiet", highs, 0);
    busRead(2'd1, rd); check(rd == 8'h00, "R11 disabled no done", rd, 8'h00);
    busRead(2'd2, rd); check(rd == 8'h77, "R11 disabled data held", rd, 8'h77);

    // Vector table walk
    for (int v = 0; v < 6; v++) begin
      logic m, s, l, ie;
      logic [7:0] tx, rx;
      {m, s, l, ie, tx, rx} = VEC[v];
      busWrite(2'd0, {3'b000, ie, 1'b1, l, s, m});
      if (m) begin
        runMaster(tx, rx, l, 1'b0, capt, rises, spacing);
        check(rises == 8, "R2 eight pulses", rises, 8);
        check(!sclkOut, "R2 clock idles low", sclkOut, 0);
        check(spacing == (s ? 16 : 2), "R3 clock period", spacing, s ? 16 : 2);
      end else begin
        runSlave(tx, rx, l, capt);
      end
      check(capt == tx, l ? "R5 tx LSB first" : "R4 tx MSB first", capt, tx);
      check(irq == ie, "R10 irq gating", irq, ie);
      busRead(2'd1, rd); check(rd == 8'h80, "R7 done flag", rd, 8'h80);
      busRead(2'd2, rd);
      check(rd == rx, m ? "R4 rx byte master" : "R6 rx byte slave", rd, rx);
      busRead(2'd1, rd); check(rd == 8'h00, "R9 flags cleared", rd, 8'h00);
      check(!irq, "R10 irq drops", irq, 0);
    end

    // R8 collision during a slow master transfer
    busWrite(2'd0, 8'h0B);
    runMaster(8'hC3, 8'h96, 1'b0, 1'b1, capt, rises, spacing);
    check(capt == 8'hC3, "R8 byte not corrupted", capt, 8'hC3);
    busRead(2'd1, rd); check(rd == 8'hC0, "R8 collision flag", rd, 8'hC0);
    busRead(2'd2, rd); check(rd == 8'h96, "R8 rx intact", rd, 8'h96);
    busRead(2'd1, rd); check(rd == 8'h00, "R9 collision cleared", rd, 8'h00);

    // R9 data access without status read keeps the flag
    busWrite(2'd0, 8'h09);
    runMaster(8'h5C, 8'h21, 1'b0, 1'b0, capt, rises, spacing);
    busRead(2'd2, rd); check(rd == 8'h21, "R4 rx before status", rd, 8'h21);
    busRead(2'd1, rd); check(rd == 8'h80, "R9 flag kept", rd, 8'h80);
    busRead(2'd2, rd);
    busRead(2'd1, rd); check(rd == 8'h00, "R9 flag cleared", rd, 8'h00);

    // R11 abort mid-transfer
    busWrite(2'd0, 8'h0B);
    busWrite(2'd2, 8'h33);
    repeat (30) @(negedge clk);
    busWrite(2'd0, 8'h01);
    repeat (2) @(negedge clk);
    check(!sclkOut && !serOut, "R11 abort pins low", {sclkOut, serOut}, 2'b00);
    repeat (140) @(negedge clk);
    busRead(2'd1, rd); check(rd == 8'h00, "R11 abort no done", rd, 8'h00);

    summaryDone = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule